// File: doc/BRIEF.md
# Instruction Cycle Timing and Interrupt Sequencer

This block sets the step timing for a small accumulator machine and chooses whether each pass through the step sequence is a normal fetch or an interrupt cycle. A 4-bit step counter drives a one-hot bank of sixteen step strobes. A 3-to-8 decoder turns the opcode field of the instruction into eight one-hot operation lines. Three flags are kept here: the indirect bit, the interrupt-enable bit and the interrupt-cycle bit.

The executing instruction ends its sequence by raising a clear request, which sends the counter back to step 0. At step 0 the interrupt-cycle bit selects the path. When it is 0, steps 0 to 2 fetch and decode the instruction, and step 2 captures the indirect bit. When it is 1, the interrupt path runs steps 0 to 2. At step 2 of that path the interrupt-enable bit, the interrupt-cycle bit and the counter all clear together. A pending interrupt is only accepted outside steps 0 to 2, so it never breaks into a fetch.

Top module: `instr_sequencer`

## Requirements
- R1: `step_o` is always one-hot. Bit k is high when the step counter holds k.
- R2: When no clear applies, the counter advances by one on every clock edge, and step 15 wraps to step 0.
- R3: A clock edge with `sc_clr_i` = 1 puts the sequencer at step 0 (`step_o[0]`) after that edge.
- R4: `irq_cyc_o` is set on an edge where steps 0, 1 and 2 are all inactive, `int_en_o` = 1, and `in_flag_i` or `out_flag_i` is 1. While the interrupt path is off, it never becomes set from steps 0, 1 or 2.
- R5: An edge with `irq_cyc_o` = 1 at step 2 clears `irq_cyc_o`, `int_en_o` and the counter, all together.
- R6: `op_o[k]` is high exactly when `ir_hi_i[2:0]` = k. This is combinational.
- R7: On an edge at step 2 with `irq_cyc_o` = 0, `ind_o` loads `ir_hi_i[3]`. On every other edge `ind_o` holds its value.
- R8: An edge with `int_off_i` = 1 clears `int_en_o`. Otherwise an edge with `int_on_i` = 1 sets it. Otherwise it holds, except as stated in R5.
- R9: After reset, the sequencer is at step 0 and `irq_cyc_o`, `int_en_o` and `ind_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_hi_i | input | 4 | Instruction bits: [2:0] is the opcode, [3] is the indirect bit |
| in_flag_i | input | 1 | Input device ready flag |
| out_flag_i | input | 1 | Output device ready flag |
| int_on_i | input | 1 | Strobe from the instruction that enables interrupts |
| int_off_i | input | 1 | Strobe from the instruction that disables interrupts |
| sc_clr_i | input | 1 | Request to clear the step counter |
| step_o | output | 16 | One-hot step strobes |
| op_o | output | 8 | One-hot opcode lines |
| ind_o | output | 1 | Indirect flag |
| int_en_o | output | 1 | Interrupt enable flag |
| irq_cyc_o | output | 1 | Interrupt-cycle flag |

## Verification
Every registered result (the step strobes, `ind_o`, `int_en_o`, `irq_cyc_o`) is due one clock edge after the inputs that cause it. The opcode lines follow `ir_hi_i` within the same cycle. The bench drives inputs on the falling edge. It advances a reference model using the inputs present at the next rising edge, and compares the registered outputs at the falling edge after that. It checks the opcode lines a short delay after each input change. Each mismatch is labelled with the requirement behind the transition that was expected in that cycle.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  localparam int unsigned SC_W_DEF = 4;
  localparam int unsigned OP_W_DEF = 3;
  localparam int unsigned FETCH_LAST = 2;  // last fetch step, also the step for the interrupt exit and the indirect load
endpackage

// File: rtl/seq_onehot_dec.sv
module seq_onehot_dec #(
  parameter int unsigned IN_W = 3,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel_i,
  output logic [OUT_N-1:0] hot_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign hot_o[k] = (sel_i == IN_W'(k));
  end
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/seq_irq_ctrl.sv
module seq_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_win_i,
  input  logic irq_done_i,
  input  logic dev_req_i,
  input  logic int_on_i,
  input  logic int_off_i,
  output logic int_en_o,
  output logic irq_cyc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   irq_cyc_o <= 1'b0;
    else if (irq_done_i)                           irq_cyc_o <= 1'b0;
    else if (!fetch_win_i && int_en_o && dev_req_i) irq_cyc_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      int_en_o <= 1'b0;
    else if (irq_done_i || int_off_i) int_en_o <= 1'b0;
    else if (int_on_i)                int_en_o <= 1'b1;
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import instr_seq_pkg::*;
#(
  parameter int unsigned SC_W = SC_W_DEF,
  parameter int unsigned OP_W = OP_W_DEF,
  localparam int unsigned STEP_N = 1 << SC_W,
  localparam int unsigned OP_N = 1 << OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W:0]     ir_hi_i,
  input  logic              in_flag_i,
  input  logic              out_flag_i,
  input  logic              int_on_i,
  input  logic              int_off_i,
  input  logic              sc_clr_i,
  output logic [STEP_N-1:0] step_o,
  output logic [OP_N-1:0]   op_o,
  output logic              ind_o,
  output logic              int_en_o,
  output logic              irq_cyc_o
);
  logic [SC_W-1:0] sc_q;
  logic            fetch_win, irq_done, load_ind;

  assign fetch_win = |step_o[FETCH_LAST:0];
  assign irq_done  = irq_cyc_o & step_o[FETCH_LAST];
  assign load_ind  = ~irq_cyc_o & step_o[FETCH_LAST];

  seq_counter #(.W(SC_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sc_clr_i | irq_done),
    .cnt_o (sc_q)
  );

  seq_onehot_dec #(.IN_W(SC_W)) u_step_dec (
    .sel_i(sc_q),
    .hot_o(step_o)
  );

  seq_onehot_dec #(.IN_W(OP_W)) u_op_dec (
    .sel_i(ir_hi_i[OP_W-1:0]),
    .hot_o(op_o)
  );

  seq_irq_ctrl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_win_i(fetch_win),
    .irq_done_i (irq_done),
    .dev_req_i  (in_flag_i | out_flag_i),
    .int_on_i   (int_on_i),
    .int_off_i  (int_off_i),
    .int_en_o   (int_en_o),
    .irq_cyc_o  (irq_cyc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ind_o <= 1'b0;
    else if (load_ind) ind_o <= ir_hi_i[OP_W];
  end
endmodule

// File: rtl/instr_sequencer_chk.sv
module instr_sequencer_chk #(
  parameter int unsigned STEP_N = 16,
  parameter int unsigned OP_N = 8,
  parameter int unsigned OP_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W:0]     ir_hi_i,
  input logic              in_flag_i,
  input logic              out_flag_i,
  input logic              int_on_i,
  input logic              int_off_i,
  input logic              sc_clr_i,
  input logic [STEP_N-1:0] step_o,
  input logic [OP_N-1:0]   op_o,
  input logic              ind_o,
  input logic              int_en_o,
  input logic              irq_cyc_o
);
  p_step_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);

  p_step_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sc_clr_i && !(irq_cyc_o && step_o[2])) |=>
      step_o == {$past(step_o[STEP_N-2:0]), $past(step_o[STEP_N-1])});

  p_clr_to_t0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_clr_i |=> step_o[0]);

  p_no_set_in_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_cyc_o && (|step_o[2:0])) |=> !irq_cyc_o);

  p_irq_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cyc_o && step_o[2]) |=> (!irq_cyc_o && !int_en_o && step_o[0]));

  p_op_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(op_o) == 1 && op_o[ir_hi_i[OP_W-1:0]]);

  p_ind_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_cyc_o && step_o[2]) |=> ind_o == $past(ir_hi_i[OP_W]));

  p_ind_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!irq_cyc_o && step_o[2]) |=> $stable(ind_o));

  p_ien_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_on_i && !int_off_i && !(irq_cyc_o && step_o[2])) |=> $stable(int_en_o));

  p_ien_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_off_i |=> !int_en_o);
endmodule

bind instr_sequencer instr_sequencer_chk #(
  .STEP_N(STEP_N), .OP_N(OP_N), .OP_W(OP_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_hi_i(ir_hi_i), .in_flag_i(in_flag_i),
  .out_flag_i(out_flag_i), .int_on_i(int_on_i), .int_off_i(int_off_i),
  .sc_clr_i(sc_clr_i), .step_o(step_o), .op_o(op_o), .ind_o(ind_o),
  .int_en_o(int_en_o), .irq_cyc_o(irq_cyc_o)
);

// File: tb/instr_sequencer_tb.sv
module instr_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ir_hi = '0;
  logic        fi = 1'b0, fo = 1'b0, ion = 1'b0, iof = 1'b0, clr = 1'b0;
  logic [15:0] step;
  logic [7:0]  op;
  logic        ind, ien, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [3:0] m_sc;
  logic       m_r, m_ien, m_i;
  string      tag_sc, tag_r, tag_ien;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_hi_i(ir_hi), .in_flag_i(fi), .out_flag_i(fo),
    .int_on_i(ion), .int_off_i(iof), .sc_clr_i(clr), .step_o(step), .op_o(op),
    .ind_o(ind), .int_en_o(ien), .irq_cyc_o(irq)
  );

  function automatic logic [15:0] exp_step(input logic [3:0] s);
    return 16'(1) << s;
  endfunction

  function automatic logic [7:0] exp_op(input logic [2:0] c);
    return 8'(1) << c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs();
    chk(tag_sc, 32'(step), 32'(exp_step(m_sc)));
    chk(tag_r, 32'(irq), 32'(m_r));
    chk(tag_ien, 32'(ien), 32'(m_ien));
    chk("R7 indirect flag", 32'(ind), 32'(m_i));
  endtask

  // drive one cycle of inputs at a falling edge, advance the model, wait for the next falling edge and compare
  task automatic step_cyc(input logic [3:0] ir, input logic f_in, input logic f_out,
                          input logic on, input logic off, input logic c);
    logic done_irq, fetch;
    ir_hi = ir; fi = f_in; fo = f_out; ion = on; iof = off; clr = c;
    #1;
    chk("R6 opcode decode", 32'(op), 32'(exp_op(ir[2:0])));
    done_irq = m_r && (m_sc == 4'd2);
    fetch = (m_sc <= 4'd2);
    tag_sc = done_irq ? "R5 step clear" : (c ? "R3 clear request" : "R2 advance");
    tag_r = "R4 irq cycle flag";
    tag_ien = "R8 enable flag";
    if (!m_r && m_sc == 4'd2) m_i = ir[3];
    if (done_irq) begin
      m_r = 1'b0; tag_r = "R5 irq flag clear";
      m_ien = 1'b0; tag_ien = "R5 enable clear";
    end else begin
      if (!fetch && m_ien && (f_in || f_out)) m_r = 1'b1;
      if (off) m_ien = 1'b0;
      else if (on) m_ien = 1'b1;
    end
    m_sc = (done_irq || c) ? 4'd0 : m_sc + 4'd1;
    @(negedge clk);
    check_regs();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240917));
    m_sc = 0; m_r = 0; m_ien = 0; m_i = 0;
    repeat (3) @(negedge clk);
    tag_sc = "R9 reset step"; tag_r = "R9 reset irq"; tag_ien = "R9 reset enable";
    check_regs();
    rst_n = 1'b1;
    @(negedge clk);
    m_sc = 4'd1;
    tag_sc = "R9 first step after reset";
    check_regs();

    // directed: full wrap through step 15 with flags set but interrupts disabled (R2, R4)
    for (int k = 0; k < 18; k++) step_cyc(4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // directed: clear request mid-sequence (R3), fetch with indirect bit loaded (R7)
    step_cyc(4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step_cyc(4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cyc(4'h9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cyc(4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // enable and disable together: disable wins (R8), then enable
    step_cyc(4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    step_cyc(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // device request during execute, then the interrupt path (R4, R5)
    step_cyc(4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step_cyc(4'h8, 1'b0, 1'b0, 1'b0, 1'b0, k == 0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      step_cyc(4'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
               ($urandom % 6) == 0, ($urandom % 10) == 0, ($urandom % 7) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule